// File: doc/BRIEF.md
# PHY Configuration Table Loader

This block brings a memory PHY out of reset by replaying a command table. On a start pulse it walks a synchronous table ROM one 32-bit word at a time. The first word gives the starting register address. Each later word is one of three things: a value to write, a marker that ends the table, or a marker saying the following word is a new target address. Ordinary values go out as single-beat writes on a simple valid/ready register bus, and the target address steps by 4 after each accepted write.

When the table ends, the block kicks PHY training. It writes zero to the PHY control register and waits a fixed settle time of about 2 µs, counted in clock cycles. It then writes a control value with the reset-release and init bits set. After that it watches the PHY status inputs until the PLL reports lock and init has cleared, and then raises `done`.

`error` is raised, and the run stops, in two cases: the current target address is below the PHY register window, or the lock condition does not arrive within the polling budget. `done` and `error` hold until the next start.

Top module: `phy_cfg_loader`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `bus_valid` are all low, and no bus write is made until `start` is pulsed.
- R2: The table word at index 0 is taken as the first target address and is never written as data.
- R3: Every table word that is neither marker is written to the current target address, and the target then advances by 4 for the next data word.
- R4: The end marker (default 0xFFFFFFFF) stops table loading at once, with no write made for it; the kick sequence follows.
- R5: The jump marker (default 0xFFFFFFFE) makes the next table word the new target address; neither word causes a write.
- R6: If the target address is below `PHY_BASE` (default 0x1000) when the next word is about to be handled, whether it is the start address or a jump target, loading aborts. No further write is made, no kick is made, and `error` is raised.
- R7: The kick writes 0 to `CTRL_ADDR` (default 0x800) and then writes 0x3 (bit 0 = reset release, bit 1 = init) to the same address. The second handshake is at least `CLK_MHZ*KICK_US + 1` cycles after the first (101 at the defaults).
- R8: `done` rises only in the cycle after one in which `phy_pll_lock` = 1 and `phy_init_busy` = 0 were seen during polling. It then stays high with the bus idle until the next start.
- R9: If that lock condition is not seen within `POLL_MAX` cycles of polling, `error` is raised and `done` stays low.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr` and `bus_wdata` hold their values.
- R11: A `start` pulse while `busy` is high is ignored. A start from idle, done or error begins a new run from table index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to run the table |
| rom_addr | output | TBL_AW | Table ROM word index |
| rom_rdata | input | 32 | Table ROM word, valid one cycle after `rom_addr` |
| bus_valid | output | 1 | Register write request |
| bus_ready | input | 1 | Register write accepted when high with `bus_valid` |
| bus_addr | output | 32 | Register write byte address |
| bus_wdata | output | 32 | Register write data |
| phy_pll_lock | input | 1 | PHY reports PLL locked |
| phy_init_busy | input | 1 | PHY reports initialisation still running |
| busy | output | 1 | Run in progress |
| done | output | 1 | Table loaded and PHY training reported complete |
| error | output | 1 | Address below PHY window, or lock timeout |

## Verification
The assertions assume the table ROM answers with registered data one cycle after the index is presented, and that `start` is a single-cycle pulse. They also assume `bus_ready` may stall for any number of cycles, and that the PHY status inputs matter only while the block is polling. The bench keeps within this. Its ROM model reads on the clock edge, `bus_ready` comes from a free-running shift register so that it stalls in irregular patterns, and its PHY model raises lock and clears init only some cycles after it has seen the second kick write.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

   typedef logic [31:0] word_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_ADDR,
      ST_LD_ADDR,
      ST_CHECK,
      ST_RD_WORD,
      ST_DECODE,
      ST_WRITE,
      ST_KICK_LO,
      ST_SETTLE,
      ST_KICK_HI,
      ST_POLL,
      ST_DONE,
      ST_FAIL
   } ld_state_e;

endpackage

// File: rtl/phy_cfg_word_class.sv
module phy_cfg_word_class
   import phy_cfg_pkg::*;
#(
   parameter word_t END_MARK  = 32'hFFFF_FFFF,
   parameter word_t JUMP_MARK = 32'hFFFF_FFFE
) (
   input  word_t word,
   output logic  is_end,
   output logic  is_jump
);
   assign is_end  = (word == END_MARK);
   assign is_jump = (word == JUMP_MARK);
endmodule

// File: rtl/phy_cfg_timer.sv
module phy_cfg_timer #(
   parameter int LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT <= 1) begin : g_direct
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign expired = run;
      end else begin : g_count
         logic [CW-1:0] cnt;
         assign expired = run && (cnt == CW'(LIMIT - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt <= '0;
            else if (!run)     cnt <= '0;
            else if (!expired) cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/phy_cfg_loader.sv
module phy_cfg_loader
   import phy_cfg_pkg::*;
#(
   parameter int    TBL_AW    = 6,
   parameter word_t PHY_BASE  = 32'h0000_1000,
   parameter word_t CTRL_ADDR = 32'h0000_0800,
   parameter word_t END_MARK  = 32'hFFFF_FFFF,
   parameter word_t JUMP_MARK = 32'hFFFF_FFFE,
   parameter int    CLK_MHZ   = 50,
   parameter int    KICK_US   = 2,
   parameter int    POLL_MAX  = 4096,
   parameter int    NRST_BIT  = 0,
   parameter int    INIT_BIT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [TBL_AW-1:0] rom_addr,
   input  logic [31:0]       rom_rdata,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic [31:0]       bus_addr,
   output logic [31:0]       bus_wdata,
   input  logic              phy_pll_lock,
   input  logic              phy_init_busy,
   output logic              busy,
   output logic              done,
   output logic              error
);
   localparam int    KICK_CYC = CLK_MHZ * KICK_US;
   localparam word_t KICK_VAL = (word_t'(1) << NRST_BIT) | (word_t'(1) << INIT_BIT);

   initial begin
      assert (END_MARK != JUMP_MARK) else $error("end and jump markers must differ");
      assert (KICK_CYC > 0) else $error("settle time must be at least one cycle");
      assert (POLL_MAX > 0) else $error("poll budget must be positive");
      assert (PHY_BASE[1:0] == 2'b00) else $error("PHY base must be word aligned");
      assert (NRST_BIT != INIT_BIT && NRST_BIT < 32 && INIT_BIT < 32)
         else $error("kick bit positions invalid");
   end

   ld_state_e         state;
   logic [TBL_AW-1:0] ptr;
   word_t             cur_addr;
   word_t             wr_addr;
   word_t             wr_data;
   logic              is_end, is_jump;
   logic              settle_exp, poll_exp;
   logic              lock_ok;

   phy_cfg_word_class #(.END_MARK(END_MARK), .JUMP_MARK(JUMP_MARK)) class_i (
      .word    (rom_rdata),
      .is_end  (is_end),
      .is_jump (is_jump)
   );

   phy_cfg_timer #(.LIMIT(KICK_CYC)) settle_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_SETTLE),
      .expired (settle_exp)
   );

   phy_cfg_timer #(.LIMIT(POLL_MAX)) poll_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == ST_POLL),
      .expired (poll_exp)
   );

   assign lock_ok   = phy_pll_lock && !phy_init_busy;
   assign rom_addr  = ptr;
   assign bus_addr  = wr_addr;
   assign bus_wdata = wr_data;
   assign bus_valid = (state == ST_WRITE) || (state == ST_KICK_LO) || (state == ST_KICK_HI);
   assign done      = (state == ST_DONE);
   assign error     = (state == ST_FAIL);
   assign busy      = !(state == ST_IDLE || state == ST_DONE || state == ST_FAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ptr      <= '0;
         cur_addr <= '0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
               if (start) begin
                  ptr   <= '0;
                  state <= ST_RD_ADDR;
               end
            end
            ST_RD_ADDR: state <= ST_LD_ADDR;
            ST_LD_ADDR: begin
               cur_addr <= rom_rdata;
               ptr      <= ptr + 1'b1;
               state    <= ST_CHECK;
            end
            ST_CHECK:   state <= (cur_addr < PHY_BASE) ? ST_FAIL : ST_RD_WORD;
            ST_RD_WORD: state <= ST_DECODE;
            ST_DECODE: begin
               ptr <= ptr + 1'b1;
               if (is_end) begin
                  wr_addr <= CTRL_ADDR;
                  wr_data <= '0;
                  state   <= ST_KICK_LO;
               end else if (is_jump) begin
                  state <= ST_RD_ADDR;
               end else begin
                  wr_addr <= cur_addr;
                  wr_data <= rom_rdata;
                  state   <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (bus_ready) begin
                  cur_addr <= cur_addr + 32'd4;
                  state    <= ST_CHECK;
               end
            end
            ST_KICK_LO: if (bus_ready) state <= ST_SETTLE;
            ST_SETTLE: begin
               if (settle_exp) begin
                  wr_data <= KICK_VAL;
                  state   <= ST_KICK_HI;
               end
            end
            ST_KICK_HI: if (bus_ready) state <= ST_POLL;
            ST_POLL: begin
               if (lock_ok)       state <= ST_DONE;
               else if (poll_exp) state <= ST_FAIL;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/phy_cfg_loader_chk.sv
module phy_cfg_loader_chk #(
   parameter logic [31:0] PHY_BASE  = 32'h0000_1000,
   parameter logic [31:0] CTRL_ADDR = 32'h0000_0800
) (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        bus_valid,
   input logic        bus_ready,
   input logic [31:0] bus_addr,
   input logic [31:0] bus_wdata,
   input logic        phy_pll_lock,
   input logic        phy_init_busy,
   input logic        busy,
   input logic        done,
   input logic        error
);
   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_valid);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata)));

   assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr != CTRL_ADDR) |-> (bus_addr >= PHY_BASE));

   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !bus_valid);

   assert_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(phy_pll_lock) && !$past(phy_init_busy)));

   assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

   assert_launch_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind phy_cfg_loader phy_cfg_loader_chk #(.PHY_BASE(PHY_BASE), .CTRL_ADDR(CTRL_ADDR)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .bus_valid     (bus_valid),
   .bus_ready     (bus_ready),
   .bus_addr      (bus_addr),
   .bus_wdata     (bus_wdata),
   .phy_pll_lock  (phy_pll_lock),
   .phy_init_busy (phy_init_busy),
   .busy          (busy),
   .done          (done),
   .error         (error)
);

// File: tb/phy_cfg_loader_tb_top.sv
module phy_cfg_loader_tb_top;
   localparam logic [31:0] BASE = 32'h0000_1000;
   localparam logic [31:0] CTRL = 32'h0000_0800;
   localparam logic [31:0] ENDM = 32'hFFFF_FFFF;
   localparam logic [31:0] JMP  = 32'hFFFF_FFFE;
   localparam logic [31:0] KVAL = 32'h0000_0003;
   localparam int KICK_CYC = 100;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  rom_addr;
   logic [31:0] rom_rdata = '0;
   logic        bus_valid, bus_ready = 1'b0;
   logic [31:0] bus_addr, bus_wdata;
   logic        phy_pll_lock = 1'b0, phy_init_busy = 1'b1;
   logic        busy, done, error;

   phy_cfg_loader dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .rom_addr(rom_addr), .rom_rdata(rom_rdata),
      .bus_valid(bus_valid), .bus_ready(bus_ready),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .phy_pll_lock(phy_pll_lock), .phy_init_busy(phy_init_busy),
      .busy(busy), .done(done), .error(error)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   int kick0_cyc = 0;
   logic [31:0] rom [0:63];
   logic [63:0] exp_q[$];

   logic       stall_en = 1'b0;
   logic [7:0] lfsr = 8'h5A;
   int         phy_mode = 1;
   logic       kick_seen = 1'b0;
   int         phy_cnt = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      rom_rdata <= rom[rom_addr];
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bus_ready <= !stall_en || lfsr[0];
   end

   // PHY model: lock after the init kick, init clears only in the good mode
   always @(posedge clk) begin
      if (start) begin
         kick_seen <= 1'b0;
         phy_cnt <= 0;
         phy_pll_lock <= 1'b0;
         phy_init_busy <= 1'b1;
      end else if (kick_seen) begin
         phy_cnt <= phy_cnt + 1;
         if (phy_cnt == 10) phy_pll_lock <= 1'b1;
         if (phy_cnt == 20 && phy_mode == 1) phy_init_busy <= 1'b0;
      end else if (bus_valid && bus_ready && bus_addr == CTRL && bus_wdata == KVAL) begin
         kick_seen <= 1'b1;
      end
   end

   // Monitor: each handshake pops the scoreboard
   always @(negedge clk) begin
      if (rst_n && bus_valid && bus_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4/R6 unexpected write", {bus_addr, bus_wdata}, 64'h0);
         end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            chk({bus_addr, bus_wdata} == e, "R2/R3/R5/R7 write order", {bus_addr, bus_wdata}, e);
         end
         if (bus_addr == CTRL && bus_wdata == 32'h0) kick0_cyc = cyc;
         if (bus_addr == CTRL && bus_wdata == KVAL)
            chk((cyc - kick0_cyc) >= KICK_CYC + 1, "R7 settle gap",
                64'(cyc - kick0_cyc), 64'(KICK_CYC + 1));
      end
   end

   task automatic clear_rom();
      for (int i = 0; i < 64; i++) rom[i] = ENDM;
   endtask

   task automatic push(input logic [31:0] a, input logic [31:0] d);
      exp_q.push_back({a, d});
   endtask

   task automatic push_kicks();
      push(CTRL, 32'h0);
      push(CTRL, KVAL);
   endtask

   task automatic run_case(input string tag, input bit want_done, input bit want_err, input int restart_at);
      int n;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!(done || error) && n < 20000) begin
         @(negedge clk);
         n++;
         if (n == restart_at) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R11 busy after ignored start", 64'(busy), 64'h1);
         end
      end
      chk(done == want_done, {tag, " done"}, 64'(done), 64'(want_done));
      chk(error == want_err, {tag, " error"}, 64'(error), 64'(want_err));
      chk(exp_q.size() == 0, {tag, " writes left"}, 64'(exp_q.size()), 64'h0);
      repeat (5) @(negedge clk);
      chk(!bus_valid && done == want_done, {tag, " R8 hold idle"}, {62'h0, bus_valid, done}, {63'h0, want_done});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      clear_rom();
      repeat (3) @(negedge clk);
      chk(!busy && !done && !error && !bus_valid, "R1 reset state",
          {60'h0, busy, done, error, bus_valid}, 64'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!busy && !bus_valid, "R1 idle without start", {62'h0, busy, bus_valid}, 64'h0);

      // R2 R3 R4 R7 R8: straight table
      clear_rom();
      rom[0] = BASE; rom[1] = 32'h11; rom[2] = 32'h22; rom[3] = 32'h33; rom[4] = ENDM;
      push(BASE, 32'h11); push(BASE + 4, 32'h22); push(BASE + 8, 32'h33); push_kicks();
      phy_mode = 1;
      run_case("R3 straight", 1'b1, 1'b0, 0);

      // R5: jump marker with a stalling bus (R10)
      stall_en = 1'b1;
      clear_rom();
      rom[0] = 32'h1100; rom[1] = 32'hA1; rom[2] = JMP; rom[3] = 32'h1200;
      rom[4] = 32'hB1; rom[5] = 32'hB2; rom[6] = ENDM;
      push(32'h1100, 32'hA1); push(32'h1200, 32'hB1); push(32'h1204, 32'hB2); push_kicks();
      run_case("R5 jump", 1'b1, 1'b0, 0);

      // R4: end marker right after the start address
      clear_rom();
      rom[0] = 32'h2000; rom[1] = ENDM; rom[2] = 32'h55;
      push_kicks();
      run_case("R4 empty table", 1'b1, 1'b0, 0);

      // R6: start address one word below the window
      clear_rom();
      rom[0] = BASE - 4; rom[1] = 32'h5; rom[2] = ENDM;
      run_case("R6 low start", 1'b0, 1'b1, 0);

      // R6: jump target below the window
      clear_rom();
      rom[0] = BASE; rom[1] = 32'h7; rom[2] = JMP; rom[3] = 32'h0800; rom[4] = 32'h9; rom[5] = ENDM;
      push(BASE, 32'h7);
      run_case("R6 low jump", 1'b0, 1'b1, 0);

      // R9: lock without init clearing never completes
      stall_en = 1'b0;
      clear_rom();
      rom[0] = BASE; rom[1] = 32'h44; rom[2] = ENDM;
      push(BASE, 32'h44); push_kicks();
      phy_mode = 0;
      run_case("R9 timeout", 1'b0, 1'b1, 0);

      // R11: start mid-run is ignored; restart from the error state
      stall_en = 1'b1;
      phy_mode = 1;
      clear_rom();
      rom[0] = 32'h1100; rom[1] = 32'hC1; rom[2] = JMP; rom[3] = 32'h1300;
      rom[4] = 32'hC2; rom[5] = 32'hC3; rom[6] = 32'hC4; rom[7] = ENDM;
      push(32'h1100, 32'hC1); push(32'h1300, 32'hC2); push(32'h1304, 32'hC3);
      push(32'h1308, 32'hC4); push_kicks();
      run_case("R11 restart", 1'b1, 1'b0, 8);

      summary();
      $finish;
   end
endmodule